// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block places a multi-unit processor core into a low-power clock-stop state and brings it back out. A platform agent drives an active-low stop request that has no timing relation to the core clock. The controller first brings that request into the core clock domain. It then asks the bus interface to send an acknowledge transaction. Once the bus interface reports that the transaction has gone out, the controller lowers the clock enables of the execution units. The bus interface unit and the interrupt-controller unit keep running, so bus snooping and interrupt service continue while the core is stopped.

When the request is released, every clock enable is raised again and execution resumes. The controller never changes the bus clock. It only drives enables for the core-side gating cells, and those cells sit outside the block. If the request is withdrawn before the acknowledge has been sent, the controller still lets the acknowledge complete. It then goes back to running without gating any unit.

Top module: `stopclk_ctrl`

## Requirements
- R1: After a synchronous reset the controller reports `state_o` = 0 (running), holds `ack_req_o` low and drives every bit of `clk_en_o` high.
- R2: The stop request passes through a two-flop synchroniser. A low level on `stop_req_n` set up before a clock edge moves the controller to the acknowledge-wait state (`state_o` = 1) at the third rising edge, and not earlier.
- R3: `ack_req_o` is high for exactly one cycle, in the first cycle of the acknowledge-wait state, and at no other time.
- R4: While the controller waits for the acknowledge, all bits of `clk_en_o` stay high.
- R5: When `ack_sent` is sampled high in the acknowledge-wait state and the synchronised request is still active, the controller enters the stopped state (`state_o` = 2) at that edge. `clk_en_o` then holds only bit 0 (bus interface unit) and bit 1 (interrupt controller) high.
- R6: The enable bits of the bus interface unit and the interrupt controller are never lowered.
- R7: When `stop_req_n` goes high while the controller is stopped, the controller returns to running (`state_o` = 0) with all enables high at the third rising edge.
- R8: If the request is released during the acknowledge wait, the controller stays in the wait until `ack_sent`. It then returns to running without ever gating a unit.
- R9: `ack_sent` has no effect unless the controller is in the acknowledge-wait state.
- R10: `clk_en_o` is a register output. It changes only at a clock edge where the controller enters or leaves the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| ack_sent | input | 1 | Bus interface reports that the acknowledge transaction has been sent |
| state_o | output | 2 | Controller state: 0 running, 1 waiting for acknowledge, 2 stopped |
| ack_req_o | output | 1 | One-cycle request to the bus interface to send the acknowledge |
| clk_en_o | output | NUM_UNITS | Per-unit clock enables, registered |

## Verification
Every result has a fixed latency counted from the edge that first samples the stimulus:
- A change on `stop_req_n` shows on `state_o`, and on `ack_req_o` or `clk_en_o`, three edges later. That is two synchroniser flops plus the state register.
- An `ack_sent` pulse in the wait state acts at the very next edge.

The driver records, for each stimulus, the absolute cycle at which each output value is due. That includes the cycles just before the due edge, where the old value must still hold. The monitor samples two nanoseconds after each rising edge and compares only the entries stamped with that cycle. An entry that is seen late counts as a mismatch.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

  typedef enum logic [1:0] {
    SC_RUN     = 2'd0,
    SC_ACKWAIT = 2'd1,
    SC_GATED   = 2'd2
  } sc_state_e;

endpackage

// File: rtl/stopclk_sync.sv
// Multi-stage level synchroniser for an asynchronous input.
module stopclk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/stopclk_fsm.sv
// Sequencer: run -> wait for acknowledge -> gated, with abort path.
module stopclk_fsm
  import stopclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_active,
  input  logic      ack_sent,
  output sc_state_e state_q,
  output sc_state_e state_d,
  output logic      ack_req_q
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SC_RUN: begin
        if (req_active) state_d = SC_ACKWAIT;
      end
      SC_ACKWAIT: begin
        // The acknowledge always completes; the request level at that
        // moment decides whether gating follows.
        if (ack_sent) state_d = req_active ? SC_GATED : SC_RUN;
      end
      SC_GATED: begin
        if (!req_active) state_d = SC_RUN;
      end
      default: state_d = SC_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SC_RUN;
      ack_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ack_req_q <= (state_q == SC_RUN) && (state_d == SC_ACKWAIT);
    end
  end

endmodule

// File: rtl/stopclk_gate_en.sv
// Registered per-unit clock enables; always-on units get a constant-high flop.
module stopclk_gate_en
  import stopclk_pkg::*;
#(
  parameter int                   NUM_UNITS = 8,
  parameter logic [NUM_UNITS-1:0] KEEP_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sc_state_e            state_d,
  output logic [NUM_UNITS-1:0] en_q
);

  logic gate_d;
  assign gate_d = (state_d == SC_GATED);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    if (KEEP_MASK[u]) begin : g_keep
      always_ff @(posedge clk) begin
        en_q[u] <= 1'b1;
      end
    end else begin : g_gate
      always_ff @(posedge clk) begin
        if (rst) en_q[u] <= 1'b1;
        else     en_q[u] <= !gate_d;
      end
    end
  end

endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
  import stopclk_pkg::*;
#(
  parameter int NUM_UNITS   = 8,
  parameter int BUS_UNIT    = 0,
  parameter int IRQ_UNIT    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_req_n,
  input  logic                 ack_sent,
  output logic [1:0]           state_o,
  output logic                 ack_req_o,
  output logic [NUM_UNITS-1:0] clk_en_o
);

  localparam logic [NUM_UNITS-1:0] KEEP_MASK =
    (NUM_UNITS'(1) << BUS_UNIT) | (NUM_UNITS'(1) << IRQ_UNIT);

  logic      req_n_sync;
  logic      req_active;
  sc_state_e st_q;
  sc_state_e st_d;

  stopclk_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(stop_req_n),
    .sync_o (req_n_sync)
  );

  assign req_active = !req_n_sync;

  stopclk_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_active(req_active),
    .ack_sent  (ack_sent),
    .state_q   (st_q),
    .state_d   (st_d),
    .ack_req_q (ack_req_o)
  );

  stopclk_gate_en #(
    .NUM_UNITS(NUM_UNITS),
    .KEEP_MASK(KEEP_MASK)
  ) u_en (
    .clk    (clk),
    .rst    (rst),
    .state_d(st_d),
    .en_q   (clk_en_o)
  );

  assign state_o = st_q;

endmodule

// File: rtl/stopclk_ctrl_chk.sv
module stopclk_ctrl_chk #(
  parameter int NUM_UNITS = 8,
  parameter int BUS_UNIT  = 0,
  parameter int IRQ_UNIT  = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ack_sent,
  input logic [1:0]           state_o,
  input logic                 ack_req_o,
  input logic [NUM_UNITS-1:0] clk_en_o
);

  localparam logic [NUM_UNITS-1:0] KEEP =
    (NUM_UNITS'(1) << BUS_UNIT) | (NUM_UNITS'(1) << IRQ_UNIT);

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
    state_o != 2'd3);

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (rst)
    ack_req_o |=> !ack_req_o);

  assert_ack_on_entry_R3: assert property (@(posedge clk) disable iff (rst)
    ack_req_o |-> (state_o == 2'd1 && $past(state_o) == 2'd0));

  assert_wait_all_on_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1) |-> (&clk_en_o));

  assert_gated_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> (clk_en_o == KEEP));

  assert_keep_units_R6: assert property (@(posedge clk) disable iff (rst)
    clk_en_o[BUS_UNIT] && clk_en_o[IRQ_UNIT]);

  assert_run_all_on_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0) |-> (&clk_en_o));

  assert_gate_needs_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |->
      ($past(state_o) == 2'd1 && $past(ack_sent)));

  assert_en_edge_only_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_en_o) |-> (($past(state_o) == 2'd2) != (state_o == 2'd2)));

endmodule

bind stopclk_ctrl stopclk_ctrl_chk #(
  .NUM_UNITS(NUM_UNITS),
  .BUS_UNIT (BUS_UNIT),
  .IRQ_UNIT (IRQ_UNIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack_sent (ack_sent),
  .state_o  (state_o),
  .ack_req_o(ack_req_o),
  .clk_en_o (clk_en_o)
);

// File: tb/sim_stopclk_ctrl.sv
module sim_stopclk_ctrl;

  localparam int N = 8;
  localparam logic [N-1:0] ALL_ON  = 8'hFF;
  localparam logic [N-1:0] GATED_V = 8'h03;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stop_req_n = 1'b1;
  logic         ack_sent = 1'b0;
  logic [1:0]   state_o;
  logic         ack_req_o;
  logic [N-1:0] clk_en_o;

  int unsigned cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  typedef struct {
    int unsigned cyc;
    logic [1:0]  st;
    logic        ack;
    logic [N-1:0] en;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  stopclk_ctrl #(.NUM_UNITS(N)) u0 (
    .clk       (clk),
    .rst       (rst),
    .stop_req_n(stop_req_n),
    .ack_sent  (ack_sent),
    .state_o   (state_o),
    .ack_req_o (ack_req_o),
    .clk_en_o  (clk_en_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares entries due in the current cycle.
  always begin
    @(posedge clk);
    #2;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (e.cyc != cyc || state_o !== e.st || ack_req_o !== e.ack || clk_en_o !== e.en) begin
        n_bad++;
        $display("FAIL %s cyc=%0d/%0d: got st=%0d ack=%0b en=%h, exp st=%0d ack=%0b en=%h",
                 e.tag, cyc, e.cyc, state_o, ack_req_o, clk_en_o, e.st, e.ack, e.en);
      end
    end
  end

  task automatic expect_at(input int unsigned off, input logic [1:0] st,
                           input logic ack, input logic [N-1:0] en, input string tag);
    exp_t e;
    e.cyc = cyc + off; e.st = st; e.ack = ack; e.en = en; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Request -> acknowledge wait -> gated after ack_delay cycles -> release.
  task automatic full_cycle(input int ack_delay);
    stop_req_n = 1'b0;
    expect_at(1, 2'd0, 1'b0, ALL_ON, "R2 no early");
    expect_at(2, 2'd0, 1'b0, ALL_ON, "R2 no early");
    expect_at(3, 2'd1, 1'b1, ALL_ON, "R2/R3 enter wait");
    expect_at(4, 2'd1, 1'b0, ALL_ON, "R3/R4 pulse ends");
    step(4);
    for (int i = 0; i < ack_delay; i++) begin
      expect_at(1, 2'd1, 1'b0, ALL_ON, "R4 waiting");
      step(1);
    end
    ack_sent = 1'b1;
    expect_at(1, 2'd2, 1'b0, GATED_V, "R5 gate");
    step(1);
    ack_sent = 1'b0;
    expect_at(1, 2'd2, 1'b0, GATED_V, "R6 hold");
    step(1);
    ack_sent = 1'b1;
    expect_at(1, 2'd2, 1'b0, GATED_V, "R9 ack in gated");
    step(1);
    ack_sent = 1'b0;
    stop_req_n = 1'b1;
    expect_at(1, 2'd2, 1'b0, GATED_V, "R10 unchanged");
    expect_at(2, 2'd2, 1'b0, GATED_V, "R10 unchanged");
    expect_at(3, 2'd0, 1'b0, ALL_ON, "R7 resume");
    step(4);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    expect_at(1, 2'd0, 1'b0, ALL_ON, "R1 reset");
    step(2);

    // R9: ack_sent while running has no effect
    ack_sent = 1'b1;
    expect_at(1, 2'd0, 1'b0, ALL_ON, "R9 ack in run");
    expect_at(2, 2'd0, 1'b0, ALL_ON, "R9 ack in run");
    step(2);
    ack_sent = 1'b0;
    step(1);

    full_cycle(0);
    full_cycle(2);
    full_cycle(5);

    // R8: release during wait, acknowledge completes, no gating
    stop_req_n = 1'b0;
    expect_at(3, 2'd1, 1'b1, ALL_ON, "R8 enter wait");
    step(4);
    stop_req_n = 1'b1;
    for (int i = 1; i <= 4; i++) expect_at(i, 2'd1, 1'b0, ALL_ON, "R8 still waiting");
    step(4);
    ack_sent = 1'b1;
    expect_at(1, 2'd0, 1'b0, ALL_ON, "R8 back to run");
    step(1);
    ack_sent = 1'b0;
    expect_at(1, 2'd0, 1'b0, ALL_ON, "R8 no gating");
    step(2);

    // R5: ack_sent already high when the wait begins gates at the next edge
    ack_sent = 1'b1;
    stop_req_n = 1'b0;
    expect_at(3, 2'd1, 1'b1, ALL_ON, "R5 wait with ack high");
    expect_at(4, 2'd2, 1'b0, GATED_V, "R5 immediate gate");
    step(4);
    ack_sent = 1'b0;
    stop_req_n = 1'b1;
    expect_at(3, 2'd0, 1'b0, ALL_ON, "R7 resume");
    step(4);

    // R1: reset from the stopped state
    stop_req_n = 1'b0;
    step(4);
    ack_sent = 1'b1;
    step(1);
    ack_sent = 1'b0;
    rst = 1'b1;
    stop_req_n = 1'b1;
    expect_at(1, 2'd0, 1'b0, ALL_ON, "R1 reset from gated");
    step(2);
    rst = 1'b0;

    step(6);
    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL R1 %0d expected items never compared (exp 0)", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired (exp completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule